// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

The block turns a stereo pair of 16-bit PCM samples into a three-wire serial audio stream: a bit clock, a word clock and a data line. It runs from a system clock at 512 times the audio sample rate and makes the bit-clock timing itself. A phase accumulator spreads 48 or 64 bit-clock periods evenly over each 512-cycle sample period, so no second clock is needed.

A 2-bit format select picks one of four frame layouts. Three layouts use 48 bit clocks per frame, with the word placed at the end of each 24-bit channel slot. Those words are 16, 18 or 20 bits long, and the extra low bits are zero. The fourth layout uses 64 bit clocks per frame, with the word placed at the start of each 32-bit channel slot, one bit clock late.

A new sample pair is latched on a valid strobe and goes out from the next frame. If no new pair arrives, the last pair is sent again. The format select is read only at a frame boundary.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is held, and until the first bit-clock fall after it, bclk is 1, lrck is 0 and sdata is 0. The first frame starts with the left slot and carries zero samples, because no valid strobe has arrived yet.
- R2: Every 512 system clocks hold exactly N bit-clock periods. N is 48 for formats 00, 01 and 10, and 64 for format 11. At N=48 each bit-clock half period lasts 5 or 6 system clocks; at N=64 it lasts exactly 4.
- R3: lrck is 1 during the first N/2 bit clocks of a frame, which carry the left sample, and 0 during the last N/2, which carry the right sample. lrck and sdata change only in the cycle in which bclk falls, so a receiver samples on the rising edge. Data goes out MSB first.
- R4: Format 00: within each 24-bit slot (slot bit 0 is sent first), slot bits 0 to 7 are zero and slot bits 8 to 23 carry sample bits 15 down to 0.
- R5: Format 01: slot bits 0 to 5 are zero, slot bits 6 to 21 carry sample bits 15 down to 0, and slot bits 22 and 23 are zero.
- R6: Format 10: slot bits 0 to 3 are zero, slot bits 4 to 19 carry sample bits 15 down to 0, and slot bits 20 to 23 are zero.
- R7: Format 11: within each 32-bit slot, slot bit 0 is zero, slot bits 1 to 16 carry sample bits 15 down to 0, and slot bits 17 to 31 are zero.
- R8: A pair presented with smp_vld high is sent from the next frame start onward. It is repeated in every later frame until a new pair is presented.
- R9: fmt_sel is read only in the cycle that starts a frame, so a frame never mixes two layouts. A value present in that cycle governs that frame; a change made one cycle later waits for the following frame.
- R10: If smp_vld is high in the very cycle that starts a frame, the pair presented with it goes into that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 512 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_l | input | 16 | Left sample, two's complement |
| smp_r | input | 16 | Right sample, two's complement |
| smp_vld | input | 1 | Strobe that captures smp_l and smp_r |
| fmt_sel | input | 2 | Frame layout select (00, 01, 10, 11) |
| bclk | output | 1 | Serial bit clock |
| lrck | output | 1 | Word clock, 1 for the left slot |
| sdata | output | 1 | Serial data, changes on falling bclk |

## Verification
Two events can fall in the same system-clock cycle. One is a sample strobe or a format-select change. The other is the frame-start load that copies the held pair and the selected layout into the frame registers. The bench sees the word clock rise in the cycle after a frame start, and frames are exactly 512 cycles apart, so it can drive the strobe or the new select in the cycle just before the next frame-start edge. It judges the result from the whole captured frame. The new pair or layout must appear in that same frame. A select changed one cycle after a boundary must leave that frame in the old layout and show only in the next one.

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] smp_l,
  input  logic [15:0] smp_r,
  input  logic        smp_vld,
  input  logic [1:0]  fmt_sel,
  output logic        bclk,
  output logic        lrck,
  output logic        sdata
);

  localparam int SW    = 16;
  localparam int ACCW  = 8;
  localparam int IDXW  = 6;

  logic [ACCW-1:0] acc;
  logic            bclk_q;
  logic [IDXW-1:0] idx;
  logic [1:0]      fmt_act;
  logic [SW-1:0]   hold_l, hold_r, frm_l, frm_r;
  logic [4:0]      top;

  wire             wide  = (fmt_act == 2'b11);
  wire [ACCW:0]    inc   = wide ? 9'd64 : 9'd48;
  wire [ACCW:0]    sum   = {1'b0, acc} + inc;
  wire             tick  = sum[ACCW];
  wire             fall  = tick & bclk_q;
  wire [IDXW-1:0]  last  = wide ? 6'd63 : 6'd47;
  wire [IDXW-1:0]  half  = wide ? 6'd32 : 6'd24;
  wire             wrap  = (idx >= last);
  wire             left  = (idx < half);
  wire [IDXW-1:0]  pos   = left ? idx : idx - half;
  wire [SW-1:0]    word  = left ? frm_l : frm_r;
  wire [6:0]       diff  = {2'b00, top} - {1'b0, pos};
  wire             in_wd = !diff[6] && (diff < 7'(SW));

  always_comb begin
    case (fmt_act)
      2'b00:   top = 5'd23;
      2'b01:   top = 5'd21;
      2'b10:   top = 5'd19;
      default: top = 5'd16;
    endcase
  end

  assign bclk  = bclk_q;
  assign lrck  = left;
  assign sdata = in_wd & word[diff[3:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      bclk_q  <= 1'b1;
      idx     <= '1;
      fmt_act <= 2'b00;
      hold_l  <= '0;
      hold_r  <= '0;
      frm_l   <= '0;
      frm_r   <= '0;
    end else begin
      acc <= sum[ACCW-1:0];
      if (tick) bclk_q <= ~bclk_q;
      if (smp_vld) begin
        hold_l <= smp_l;
        hold_r <= smp_r;
      end
      if (fall) begin
        idx <= wrap ? '0 : idx + 6'd1;
        if (wrap) begin
          fmt_act <= fmt_sel;
          frm_l   <= smp_vld ? smp_l : hold_l;
          frm_r   <= smp_vld ? smp_r : hold_r;
        end
      end
    end
  end

  logic [3:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 4'd1;
  end

  AST_BCLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= 4'd5); // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk) |-> (idx <= last)); // R2
  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(bclk)); // R3
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk)); // R3
  AST_FMT_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_act) |-> ($fell(bclk) && idx == '0)); // R9

endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] smp_l, smp_r;
  logic        smp_vld;
  logic [1:0]  fmt_sel;
  logic        bclk, lrck, sdata;

  always #10 clk = ~clk;

  pcm_serial_tx i_pcm_serial_tx (
    .clk(clk), .rst_n(rst_n), .smp_l(smp_l), .smp_r(smp_r),
    .smp_vld(smp_vld), .fmt_sel(fmt_sel),
    .bclk(bclk), .lrck(lrck), .sdata(sdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int NV = 8;
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 16'hA5C3, 16'h3C5A},
    {2'b01, 16'hFFFF, 16'h0001},
    {2'b10, 16'h8000, 16'h7FFF},
    {2'b11, 16'h1234, 16'hABCD},
    {2'b11, 16'hFFFF, 16'hFFFF},
    {2'b00, 16'h0000, 16'hFFFF},
    {2'b10, 16'h5555, 16'hAAAA},
    {2'b01, 16'h8421, 16'h1248}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string ftag(input logic [1:0] f);
    case (f)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic wait_lr_rise();
    logic pl;
    pl = lrck;
    forever begin
      @(negedge clk);
      if (!pl && lrck) break;
      pl = lrck;
    end
  endtask

  task automatic check_frame(input logic [1:0] f, input logic [15:0] l,
                             input logic [15:0] r, input string tag);
    logic [63:0] bits, lr, ebits, elr;
    logic [31:0] s32;
    logic [23:0] s24;
    logic [15:0] s;
    logic pb, pl;
    int n, cyc, last_t, gmin, gmax, nexp, h, p, gap;
    bits = '0; lr = '0; n = 0; cyc = 0; last_t = 0; gmin = 1000; gmax = 0;
    pb = bclk; pl = lrck;
    forever begin
      @(negedge clk);
      cyc++;
      if (bclk != pb) begin
        gap = cyc - last_t;
        if (gap < gmin) gmin = gap;
        if (gap > gmax) gmax = gap;
        last_t = cyc;
        if (bclk && n < 64) begin
          bits[n] = sdata;
          lr[n]   = lrck;
          n++;
        end
      end
      pb = bclk;
      if (!pl && lrck) break;
      pl = lrck;
      if (cyc > 2000) break;
    end
    nexp = (f == 2'b11) ? 64 : 48;
    h = nexp / 2;
    ebits = '0; elr = '0;
    for (int k = 0; k < nexp; k++) begin
      s = (k < h) ? l : r;
      p = (k < h) ? k : k - h;
      elr[k] = (k < h);
      if (f == 2'b11) begin
        s32 = {1'b0, s, 15'b0};
        ebits[k] = s32[31-p];
      end else begin
        s24 = {8'b0, s} << (2 * f);
        ebits[k] = s24[23-p];
      end
    end
    chk(n == nexp, {"R2 bit clocks per frame ", tag}, 64'(n), 64'(nexp));
    chk(cyc == 512, {"R2 system clocks per frame ", tag}, 64'(cyc), 64'd512);
    if (f == 2'b11)
      chk(gmin == 4 && gmax == 4, {"R2 half period ", tag},
          {32'(gmin), 32'(gmax)}, {32'd4, 32'd4});
    else
      chk(gmin >= 5 && gmax <= 6, {"R2 half period ", tag},
          {32'(gmin), 32'(gmax)}, {32'd5, 32'd6});
    chk(lr == elr, {"R3 word clock ", tag}, lr, elr);
    chk(bits == ebits, {ftag(f), " data ", tag}, bits, ebits);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fmt_sel = 2'b00; smp_l = '0; smp_r = '0; smp_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk(bclk == 1'b1, "R1 bclk in reset", 64'(bclk), 64'd1);
    chk(lrck == 1'b0, "R1 lrck in reset", 64'(lrck), 64'd0);
    chk(sdata == 1'b0, "R1 sdata in reset", 64'(sdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bclk == 1'b1 && lrck == 1'b0 && sdata == 1'b0, "R1 after release",
        {61'd0, bclk, lrck, sdata}, 64'd4);
    wait_lr_rise();
    check_frame(2'b00, 16'h0000, 16'h0000, "R1 first frame");

    for (int i = 0; i < NV; i++) begin
      fmt_sel = VEC[i][33:32];
      smp_l   = VEC[i][31:16];
      smp_r   = VEC[i][15:0];
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      smp_l = '0; smp_r = '0;
      wait_lr_rise();
      check_frame(VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], "R8 vector");
    end

    check_frame(2'b01, 16'h8421, 16'h1248, "R8 repeat without strobe");

    repeat (511) @(negedge clk);
    smp_l = 16'hC0DE; smp_r = 16'h0F0F; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0; smp_l = '0; smp_r = '0;
    chk(lrck == 1'b1, "R10 frame start alignment", 64'(lrck), 64'd1);
    check_frame(2'b01, 16'hC0DE, 16'h0F0F, "R10 strobe on load cycle");

    repeat (511) @(negedge clk);
    fmt_sel = 2'b11;
    @(negedge clk);
    check_frame(2'b11, 16'hC0DE, 16'h0F0F, "R9 select on boundary");
    fmt_sel = 2'b10;
    check_frame(2'b11, 16'hC0DE, 16'h0F0F, "R9 late select held off");
    check_frame(2'b10, 16'hC0DE, 16'h0F0F, "R9 late select applied");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule